// File: doc/BRIEF.md
# Hash Message Padding Unit

This block sits between a host data path and a hash compression core. It takes a message as a stream of 32-bit words and hands the core padded 512-bit blocks, sixteen 32-bit words per block, over a valid/ready stream. Before padding, each word can be byte-reversed, so a host that packs bytes least-significant first still delivers the message in big-endian order.

The most recent input word is held back until the block knows whether it ends the message. Finalization has two triggers: a one-cycle command pulse, or a last-transfer flag that travels with a data word. At that point the block takes a count of valid bits for the held word and forms the final word. If the count is nonzero, the word is cut after that many bits and a single one bit is placed behind them. If the count is zero, the word stays whole and a new word starting with the one bit follows it. Zero words follow up to word 14 of a block. Words 14 and 15 carry the 64-bit message length, high word first. A busy flag blocks new data and new commands until the core has taken the last padded word.

Top module: `hash_pad_top`

## Requirements
- R1: With `le_mode`=1, each input word is byte-reversed before any other processing, so input bits [7:0] become output bits [31:24]. With `le_mode`=0, words pass unchanged. Output words are big-endian: bit 31 is the earliest message bit.
- R2: Every accepted data word comes out in order through `out_valid`/`out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and the flags hold steady.
- R3: When `last_bits`=N is in 1..31 at finalization and a data word is held, the final word keeps its top N bits. Bit 31-N is set to 1 and bits below it are cleared.
- R4: When `last_bits`=0 at finalization, the held word goes out unchanged and the next word is 0x80000000. If the message is empty, the first word is 0x80000000.
- R5: Zero words follow the terminator until word index 14 of the current block. Word 14 carries bits [63:32] of the message bit length and word 15 carries bits [31:0]. The length is 32 x (words - 1) + N, or 32 x words when N = 0.
- R6: When the terminator lands at word index 14 or 15, that block is filled with zeros. A further block of zeros then carries the length in words 14 and 15.
- R7: `out_blast` is high exactly on word 15 of every block. `out_mlast` is high only on the final length word of a message.
- R8: A `fin_cmd` pulse while not busy starts finalization. A data word accepted in the same cycle counts as the last word.
- R9: A data word accepted with `in_dlast`=1 is the last word. Finalization starts with no command, using `last_bits` from that cycle.
- R10: `busy` rises in the cycle after a finalize trigger and stays high until the `out_mlast` word is accepted. While `busy` is high, `in_ready` is low and `fin_cmd` has no effect.
- R11: After reset, `out_valid` and `busy` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| le_mode | input | 1 | 1: byte-reverse input words |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Data word can be taken |
| in_data | input | 32 | Message data word |
| in_dlast | input | 1 | Transfer flag marking the last data word |
| last_bits | input | 5 | Valid bits in the last word (0 = full) |
| fin_cmd | input | 1 | Finalize command pulse |
| busy | output | 1 | Finalization in progress |
| out_valid | output | 1 | Padded word offered |
| out_ready | input | 1 | Core takes the padded word |
| out_data | output | 32 | Padded word |
| out_blast | output | 1 | Word 15 of a block |
| out_mlast | output | 1 | Final word of the message |

## Verification
A data write and a finalize command can fall in the same cycle. The bench raises `in_valid` and `fin_cmd` together, with `in_ready` known to be high. It then judges the result from the scoreboard's expected stream: the word must be padded as the last word, and the length must count it. Finalize commands and data words offered while busy must also leave no trace. This is checked by holding `out_ready` low during a finalization and injecting a stray word and pulse. The bench then confirms that no extra words appear and that the next message's length excludes the stray word.

// File: rtl/hash_pad_pkg.sv
// Shared types for the message padding unit.
package hash_pad_pkg;
    // Word generator phases after finalization begins.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_TAIL  = 3'd1,
        PH_ONE   = 3'd2,
        PH_ZERO  = 3'd3,
        PH_LENLO = 3'd4
    } pad_phase_e;
endpackage

// File: rtl/hash_pad_bswap.sv
// Byte order unit: reverses the byte order of a word when enabled.
// Assumes WORD_W is a multiple of 8.
module hash_pad_bswap #(
    parameter int WORD_W = 32
) (
    input  logic              en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] rev;

    // One lane per byte: byte b takes mirrored byte NBYTES-1-b.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign rev[8*b +: 8] = din[WORD_W - 8*(b+1) +: 8];
    end

    // Select reversed or straight word.
    assign dout = en ? rev : din;
endmodule

// File: rtl/hash_pad_term.sv
// Terminator former: keeps the top nbits message bits of a word, sets the
// next bit and clears the rest. Assumes nbits is nonzero when used.
module hash_pad_term #(
    parameter int WORD_W = 32,
    parameter int NB_W   = 5
) (
    input  logic [WORD_W-1:0] din,
    input  logic [NB_W-1:0]   nbits,
    output logic [WORD_W-1:0] dout
);
    localparam logic [WORD_W-1:0] ONES = '1;
    localparam logic [WORD_W-1:0] MSB  = {1'b1, {(WORD_W-1){1'b0}}};

    // Mask off unused low bits and insert the one bit after the valid ones.
    assign dout = (din & ~(ONES >> nbits)) | (MSB >> nbits);
endmodule

// File: rtl/hash_pad_lenacc.sv
// Length accumulator: counts message bits, a full word per accepted word,
// and corrects for a partial last word at the finalize trigger.
// Assumes add and clr never coincide.
module hash_pad_lenacc #(
    parameter int WORD_W = 32,
    parameter int NB_W   = 5,
    parameter int LEN_W  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add,
    input  logic             fix,
    input  logic             part,
    input  logic [NB_W-1:0]  nbits,
    output logic [LEN_W-1:0] len
);
    localparam logic [LEN_W-1:0] WBITS = LEN_W'(WORD_W);

    logic [LEN_W-1:0] base;

    // Running count including a word accepted this cycle.
    assign base = add ? len + WBITS : len;

    // Update the count; a partial last word contributes nbits, not a full word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            len <= '0;
        end else if (fix && part) begin
            len <= base - WBITS + LEN_W'(nbits);
        end else begin
            len <= base;
        end
    end
endmodule

// File: rtl/hash_pad_top.sv
// Message padding unit top. Holds back the latest data word until the
// message end is known, then emits terminator, zero fill and 64-bit length
// in 16-word blocks through a registered valid/ready output stage.
// Assumes BLK_WORDS is at least 4 and LEN_W is twice WORD_W.
module hash_pad_top #(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          le_mode,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [WORD_W-1:0]             in_data,
    input  logic                          in_dlast,
    input  logic [$clog2(WORD_W)-1:0]     last_bits,
    input  logic                          fin_cmd,
    output logic                          busy,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [WORD_W-1:0]             out_data,
    output logic                          out_blast,
    output logic                          out_mlast
);
    import hash_pad_pkg::*;

    localparam int NB_W  = $clog2(WORD_W);
    localparam int IDX_W = $clog2(BLK_WORDS);
    localparam int LEN_W = 2 * WORD_W;
    localparam logic [IDX_W-1:0] IDX_HI  = IDX_W'(BLK_WORDS - 2);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(BLK_WORDS - 1);
    localparam logic [WORD_W-1:0] TOP1   = {1'b1, {(WORD_W-1){1'b0}}};

    pad_phase_e        ph_q, ph_nx, ph_after;
    logic [WORD_W-1:0] pend_q, swapped, padded, gen_d;
    logic              pend_v;
    logic [NB_W-1:0]   nb_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len;
    logic              drain, adv, acc, trig, part, gen_v, fire;

    hash_pad_bswap #(.WORD_W(WORD_W)) u_bswap (
        .en   (le_mode),
        .din  (in_data),
        .dout (swapped)
    );

    hash_pad_term #(.WORD_W(WORD_W), .NB_W(NB_W)) u_term (
        .din   (pend_q),
        .nbits (nb_q),
        .dout  (padded)
    );

    hash_pad_lenacc #(.WORD_W(WORD_W), .NB_W(NB_W), .LEN_W(LEN_W)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fire && ph_q == PH_LENLO),
        .add   (acc),
        .fix   (trig),
        .part  (part),
        .nbits (last_bits),
        .len   (len)
    );

    // Handshake and trigger decode.
    always_comb begin
        drain    = out_valid && out_mlast;
        busy     = (ph_q != PH_IDLE) || drain;
        adv      = !out_valid || out_ready;
        in_ready = (ph_q == PH_IDLE) && !drain && (!pend_v || adv);
        acc      = in_valid && in_ready;
        trig     = (ph_q == PH_IDLE) && !drain && (fin_cmd || (acc && in_dlast));
        part     = (acc || pend_v) && (last_bits != '0);
    end

    // Word generator: selects the next word and the phase that follows it.
    always_comb begin
        gen_v    = 1'b1;
        gen_d    = '0;
        ph_after = ph_q;
        unique case (ph_q)
            PH_IDLE: begin
                gen_v = acc && pend_v;
                gen_d = pend_q;
            end
            PH_TAIL: begin
                if (!pend_v) begin
                    gen_d    = TOP1;
                    ph_after = PH_ZERO;
                end else if (nb_q != '0) begin
                    gen_d    = padded;
                    ph_after = PH_ZERO;
                end else begin
                    gen_d    = pend_q;
                    ph_after = PH_ONE;
                end
            end
            PH_ONE: begin
                gen_d    = TOP1;
                ph_after = PH_ZERO;
            end
            PH_ZERO: begin
                if (idx_q == IDX_HI) begin
                    gen_d    = len[LEN_W-1:WORD_W];
                    ph_after = PH_LENLO;
                end
            end
            PH_LENLO: begin
                gen_d    = len[WORD_W-1:0];
                ph_after = PH_IDLE;
            end
            default: begin
                gen_v    = 1'b0;
                ph_after = PH_IDLE;
            end
        endcase
        fire = gen_v && adv;
    end

    // Next phase: enter the tail on a trigger, advance on each emitted word.
    always_comb begin
        ph_nx = ph_q;
        if (ph_q == PH_IDLE) begin
            if (trig) ph_nx = PH_TAIL;
        end else if (fire) begin
            ph_nx = ph_after;
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_nx;
    end

    // Held-back word: loaded on accept, released when the tail word leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            pend_v <= 1'b0;
        end else if (acc) begin
            pend_q <= swapped;
            pend_v <= 1'b1;
        end else if (fire && ph_q == PH_TAIL) begin
            pend_v <= 1'b0;
        end
    end

    // Valid-bit count captured at the finalize trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)    nb_q <= '0;
        else if (trig) nb_q <= last_bits;
    end

    // Word index within the current block.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx_q <= '0;
        else if (fire) idx_q <= (idx_q == IDX_END) ? '0 : idx_q + 1'b1;
    end

    // Registered output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_blast <= 1'b0;
            out_mlast <= 1'b0;
        end else if (adv) begin
            out_valid <= fire;
            if (fire) begin
                out_data  <= gen_d;
                out_blast <= (idx_q == IDX_END);
                out_mlast <= (ph_q == PH_LENLO);
            end
        end
    end
endmodule

// File: rtl/hash_pad_chk.sv
// Protocol checker for the padding unit, attached by bind.
module hash_pad_chk #(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              fin_cmd,
    input logic              busy,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_blast,
    input logic              out_mlast
);
    localparam int IDX_W = $clog2(BLK_WORDS);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(BLK_WORDS - 1);

    logic [IDX_W-1:0] hs_cnt;

    // Count accepted output words modulo the block size.
    always_ff @(posedge clk) begin
        if (!rst_n) hs_cnt <= '0;
        else if (out_valid && out_ready) hs_cnt <= (hs_cnt == IDX_END) ? '0 : hs_cnt + 1'b1;
    end

    a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_blast)));

    a_r7_blast_pos: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_blast == (hs_cnt == IDX_END)));

    a_r7_mlast_ends_block: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mlast) |-> out_blast);

    a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(in_valid && in_ready));

    a_r10_trigger_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_cmd && !busy) |=> busy);
endmodule

bind hash_pad_top hash_pad_chk #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .fin_cmd   (fin_cmd),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_blast (out_blast),
    .out_mlast (out_mlast)
);

// File: tb/sim_hash_pad_top.sv
// Scoreboard bench: drivers push expected padded words, a monitor compares.
module sim_hash_pad_top;
    localparam int CLK_PER = 10;

    typedef struct {
        logic [31:0] d;
        bit          bl;
        bit          ml;
        string       req;
    } exp_t;

    logic        clk = 0, rst_n = 0, le_mode = 0, in_valid = 0, in_dlast = 0;
    logic        fin_cmd = 0, out_ready = 1;
    logic [31:0] in_data = '0;
    logic [4:0]  last_bits = '0;
    logic        in_ready, busy, out_valid, out_blast, out_mlast;
    logic [31:0] out_data;

    int          n_chk = 0, n_fail = 0, bp_mode = 0;
    exp_t        sb[$];
    logic [31:0] msg_q[$];
    logic [15:0] lfsr = 16'hACE1;

    hash_pad_top u0 (
        .clk(clk), .rst_n(rst_n), .le_mode(le_mode), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_dlast(in_dlast),
        .last_bits(last_bits), .fin_cmd(fin_cmd), .busy(busy),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_blast(out_blast), .out_mlast(out_mlast)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Output ready pattern: 0 always ready, 1 pseudo-random, 2 held low.
    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? lfsr[0] : 1'b0;
    end

    // Monitor: compare each accepted output word with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                chk(0, "R2", "unexpected word", {32'h0, out_data}, 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(out_data == e.d, e.req, "data", {32'h0, out_data}, {32'h0, e.d});
                chk(out_blast == e.bl, "R7", "block-last", {63'h0, out_blast}, {63'h0, e.bl});
                chk(out_mlast == e.ml, "R7", "msg-last", {63'h0, out_mlast}, {63'h0, e.ml});
            end
        end
    end

    // Reference model: builds the padded stream of msg_q from the rules.
    task automatic expect_msg(input int nb, input bit le, input string req);
        logic [31:0] q[$];
        logic [63:0] len;
        int n;
        n = msg_q.size();
        foreach (msg_q[i]) begin
            logic [31:0] w;
            w = msg_q[i];
            q.push_back(le ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w);
        end
        if (n > 0 && nb != 0) begin
            logic [31:0] t;
            t = q[n-1];
            for (int i = 0; i < 32; i++) begin
                if (i == nb)     t[31-i] = 1'b1;
                else if (i > nb) t[31-i] = 1'b0;
            end
            q[n-1] = t;
            len = 64'(32 * (n - 1) + nb);
        end else begin
            q.push_back(32'h8000_0000);
            len = 64'(32 * n);
        end
        while (q.size() % 16 != 14) q.push_back(32'h0);
        q.push_back(len[63:32]);
        q.push_back(len[31:0]);
        foreach (q[i]) begin
            exp_t e;
            e.d   = q[i];
            e.bl  = (i % 16 == 15);
            e.ml  = (i == q.size() - 1);
            e.req = req;
            sb.push_back(e);
        end
    endtask

    task automatic put_word(input logic [31:0] w, input bit dl);
        @(posedge clk); #1;
        in_valid = 1; in_data = w; in_dlast = dl;
        forever begin @(negedge clk); if (in_ready) break; end
        @(posedge clk); #1;
        in_valid = 0; in_dlast = 0;
    endtask

    task automatic pulse_fin(input logic [4:0] nb);
        @(posedge clk); #1;
        fin_cmd = 1; last_bits = nb;
        @(posedge clk); #1;
        fin_cmd = 0;
    endtask

    task automatic wait_drain();
        forever begin @(negedge clk); if (sb.size() == 0 && !busy) break; end
    endtask

    // mode 0: command after data, 1: last-transfer flag, 2: command with last word.
    task automatic run_msg(input int nb, input bit le, input int mode, input string req);
        int n;
        n = msg_q.size();
        le_mode = le;
        expect_msg(nb, le, req);
        for (int i = 0; i < n; i++) begin
            if (i == n - 1 && mode == 1) begin
                last_bits = 5'(nb);
                put_word(msg_q[i], 1);
            end else if (i == n - 1 && mode == 2) begin
                @(posedge clk); #1;
                in_valid = 1; in_data = msg_q[i]; fin_cmd = 1; last_bits = 5'(nb);
                @(negedge clk);
                chk(in_ready == 1, "R8", "ready with command", {63'h0, in_ready}, 64'h1);
                @(posedge clk); #1;
                in_valid = 0; fin_cmd = 0;
            end else begin
                put_word(msg_q[i], 0);
            end
        end
        if (mode == 0) pulse_fin(5'(nb));
        wait_drain();
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0, "R11", "out_valid in reset", {63'h0, out_valid}, 64'h0);
        chk(busy == 0, "R11", "busy in reset", {63'h0, busy}, 64'h0);
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        chk(in_ready == 1, "R11", "in_ready after reset", {63'h0, in_ready}, 64'h1);

        // R1 R3: three bytes, little-endian packing, 24 valid bits.
        msg_q = '{32'hAA63_6261};
        run_msg(24, 1, 0, "R3");

        // R1 R4: full words, big-endian, count zero.
        msg_q = '{32'h0102_0304, 32'h1122_3344, 32'hA5A5_5A5A};
        run_msg(0, 0, 0, "R4");

        // R9: last-transfer flag with a partial word, under back-pressure.
        bp_mode = 1;
        msg_q = '{32'hDEAD_BEEF, 32'hCAFE_F00D};
        run_msg(8, 1, 1, "R9");
        bp_mode = 0;

        // R6: 14 full words push the terminator to index 14.
        msg_q.delete();
        for (int i = 0; i < 14; i++) msg_q.push_back(32'h0101_0101 * (i + 1));
        run_msg(0, 0, 0, "R6");

        // R5: 14 words with 31 valid bits fill exactly one block.
        run_msg(31, 0, 0, "R5");

        // R6: 15 full words put the terminator at index 15.
        msg_q.push_back(32'h7777_8888);
        bp_mode = 1;
        run_msg(0, 1, 1, "R6");
        bp_mode = 0;

        // R4: empty message.
        msg_q.delete();
        run_msg(0, 0, 0, "R4");

        // R8: command in the same cycle as the last data word.
        msg_q = '{32'h1234_5678, 32'h9ABC_DEF0};
        run_msg(12, 0, 2, "R8");

        // R10: stray word and command while busy are ignored.
        msg_q = '{32'h0BAD_F00D, 32'h5555_AAAA, 32'h3333_CCCC};
        le_mode = 0;
        expect_msg(16, 0, "R10");
        foreach (msg_q[i]) put_word(msg_q[i], 0);
        bp_mode = 2;
        pulse_fin(5'd16);
        @(negedge clk);
        chk(busy == 1, "R10", "busy after command", {63'h0, busy}, 64'h1);
        @(posedge clk); #1;
        in_valid = 1; in_data = 32'hFFFF_0000; fin_cmd = 1; last_bits = 5'd4;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(in_ready == 0, "R10", "in_ready while busy", {63'h0, in_ready}, 64'h0);
        end
        @(posedge clk); #1;
        in_valid = 0; fin_cmd = 0;
        bp_mode = 1;
        wait_drain();
        bp_mode = 0;
        repeat (20) @(negedge clk);
        chk(out_valid == 0, "R10", "no output after drain", {63'h0, out_valid}, 64'h0);

        // R10: next message length must exclude the stray word.
        msg_q = '{32'h4242_4242};
        run_msg(0, 0, 0, "R10");

        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R2", "scoreboard empty", 64'(sb.size()), 64'h0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule